// File: doc/BRIEF.md
# Asymmetric Prescaled Serial Clock Generator

This block derives a serial-interface clock from the system clock for a shift-register neighbour. A power-of-two prescaler first turns the system clock into a stream of one-cycle "scaled ticks", one every 2^S system cycles. A three-state machine then holds the serial clock at each level for its own programmed number of ticks. The high time and the low time are set separately, so the duty cycle can be asymmetric. Setting either count to zero selects a plain 50% toggle, one tick per level.

While `enable` is low the serial clock rests at the level given by `cpol`. On enable the clock first moves away from that idle level. The block marks each transition with a single-cycle strobe. `lead_pulse` marks a move away from the idle level and `trail_pulse` marks a return to it. The shifter uses these strobes instead of watching the clock.

The machine has three states:
- `ST_IDLE`: disabled, clock at the idle level.
- `ST_ACTIVE`: clock at the non-idle level.
- `ST_REST`: running, clock back at the idle level.

Its transitions are:
- START: `ST_IDLE` to `ST_ACTIVE` when `enable` is sampled high.
- TRAIL: `ST_ACTIVE` to `ST_REST` when the active phase count expires.
- LEAD: `ST_REST` to `ST_ACTIVE` when the rest phase count expires.
- STOP: `ST_ACTIVE` or `ST_REST` to `ST_IDLE` when `enable` is sampled low.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is asserted and at the first edge after it, `sclk` is 0 and both strobes are 0.
- R2: While disabled, `sclk` takes the value of `cpol` one clock edge after `cpol` is sampled, and no strobe is raised.
- R3: The first clock edge that samples `enable` high drives `sclk` to the non-idle level (not `cpol`). `lead_pulse` is 1 for that one following system cycle.
- R4: After the active phase, `sclk` returns to the idle level and `trail_pulse` is 1 for that one cycle. Lead and trail then alternate, and each strobe coincides with the `sclk` change it marks.
- R5: With `cpol`=0 the high level lasts `hi_cnt`×2^S system cycles and the low level lasts `lo_cnt`×2^S cycles. With `cpol`=1 the active (low) phase uses `lo_cnt` and the rest (high) phase uses `hi_cnt`. Counts run from 1 to 255.
- R6: `scale` (S, 0 to 15) multiplies every phase length by 2^S. The prescaler restarts from zero on each START.
- R7: If `hi_cnt` or `lo_cnt` is 0, every phase lasts exactly one scaled tick (2^S system cycles).
- R8: A phase's length is captured from `hi_cnt`/`lo_cnt` when the phase is entered. Changes made during a phase affect only phases entered afterwards.
- R9: The first edge that samples `enable` low returns `sclk` to `cpol` at that edge, with no strobe, even in the middle of a phase. A later START begins a fresh, full-length active phase.
- R10: `lead_pulse` and `trail_pulse` are never high together, and `sclk` never changes while enabled without one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces the idle level |
| cpol | input | 1 | Idle level of the serial clock |
| scale | input | SCALE_W (4) | Prescale exponent S |
| hi_cnt | input | CNT_W (8) | Scaled ticks spent high |
| lo_cnt | input | CNT_W (8) | Scaled ticks spent low |
| sclk | output | 1 | Serial clock |
| lead_pulse | output | 1 | One-cycle strobe on a move away from the idle level |
| trail_pulse | output | 1 | One-cycle strobe on a return to the idle level |

## Verification
The level checks on the strobes compare `sclk` with the live `cpol`, so they assume polarity is changed only while `enable` is low. The stimulus changes `cpol` only before each run starts or after it has stopped. The stability property allows `sclk` to move without a strobe only in the cycle after `enable` was low, which covers both idle polarity changes and STOP. Count fields are altered mid-run in one scenario only, to show the capture at phase entry.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_REST   = 2'd2
    } sclk_state_e;

endpackage

// File: rtl/sclk_prescaler.sv
// Power-of-two tick generator: one tick every 2^scale cycles while run is high.
module sclk_prescaler #(
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);
    localparam int CW = (1 << SCALE_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] mask;

    // mask has its low `scale` bits set: terminal count of the divider
    for (genvar g = 0; g < CW; g++) begin : g_mask
        assign mask[g] = (scale > SCALE_W'(g));
    end

    assign tick = run && (cnt == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/sclk_phase_timer.sv
// Counts scaled ticks within one phase; length captured at load.
module sclk_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             tick,
    output logic             done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_q;

    assign done = tick && (cnt == last_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            last_q <= '0;
        end else if (load) begin
            cnt    <= '0;
            last_q <= load_len - CNT_W'(1);
        end else if (tick) begin
            cnt    <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sclk_edge_fsm.sv
// Phase sequencer: idle / active level / rest level, with edge strobes.
module sclk_edge_fsm
    import sclk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cpol,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic             phase_done,
    output logic             run,
    output logic             load,
    output logic [CNT_W-1:0] load_len,
    output logic             sclk,
    output logic             lead_pulse,
    output logic             trail_pulse
);
    sclk_state_e state, nxt;

    logic             duty_off;
    logic [CNT_W-1:0] active_len;
    logic [CNT_W-1:0] rest_len;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (enable) nxt = ST_ACTIVE;
            ST_ACTIVE: begin
                if (!enable)        nxt = ST_IDLE;
                else if (phase_done) nxt = ST_REST;
            end
            ST_REST: begin
                if (!enable)        nxt = ST_IDLE;
                else if (phase_done) nxt = ST_ACTIVE;
            end
            default:   nxt = ST_IDLE;
        endcase
    end

    // phase length chosen for the phase being entered
    always_comb begin
        duty_off   = (hi_cnt == '0) || (lo_cnt == '0);
        active_len = cpol ? lo_cnt : hi_cnt;
        rest_len   = cpol ? hi_cnt : lo_cnt;
        if (duty_off)                load_len = CNT_W'(1);
        else if (nxt == ST_ACTIVE)   load_len = active_len;
        else                         load_len = rest_len;
    end

    assign run  = (state != ST_IDLE);
    assign load = (nxt != ST_IDLE) && (nxt != state);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk        <= 1'b0;
            lead_pulse  <= 1'b0;
            trail_pulse <= 1'b0;
        end else begin
            sclk        <= cpol ^ (nxt == ST_ACTIVE);
            lead_pulse  <= (nxt == ST_ACTIVE) && (state != ST_ACTIVE);
            trail_pulse <= (state == ST_ACTIVE) && (nxt == ST_REST);
        end
    end
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
    parameter int SCALE_W = 4,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cpol,
    input  logic [SCALE_W-1:0] scale,
    input  logic [CNT_W-1:0]   hi_cnt,
    input  logic [CNT_W-1:0]   lo_cnt,
    output logic               sclk,
    output logic               lead_pulse,
    output logic               trail_pulse
);
    logic             run;
    logic             tick;
    logic             load;
    logic             phase_done;
    logic [CNT_W-1:0] load_len;

    sclk_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .scale (scale),
        .tick  (tick)
    );

    sclk_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_len (load_len),
        .tick     (tick),
        .done     (phase_done)
    );

    sclk_edge_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .cpol        (cpol),
        .hi_cnt      (hi_cnt),
        .lo_cnt      (lo_cnt),
        .phase_done  (phase_done),
        .run         (run),
        .load        (load),
        .load_len    (load_len),
        .sclk        (sclk),
        .lead_pulse  (lead_pulse),
        .trail_pulse (trail_pulse)
    );
endmodule

// File: rtl/sclk_gen_checker.sv
module sclk_gen_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cpol,
    input logic sclk,
    input logic lead_pulse,
    input logic trail_pulse
);
    assert_excl_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead_pulse && trail_pulse));

    assert_lead_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lead_pulse |-> (sclk != cpol));

    assert_trail_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trail_pulse |-> (sclk == cpol));

    assert_lead_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lead_pulse |=> !lead_pulse);

    assert_trail_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trail_pulse |=> !trail_pulse);

    assert_idle_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(enable)) |->
            ((sclk == $past(cpol)) && !lead_pulse && !trail_pulse));

    assert_no_silent_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sclk) |-> (lead_pulse || trail_pulse || !$past(enable)));
endmodule

bind spi_sclk_gen sclk_gen_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .cpol        (cpol),
    .sclk        (sclk),
    .lead_pulse  (lead_pulse),
    .trail_pulse (trail_pulse)
);

// File: tb/sim_spi_sclk_gen.sv
module sim_spi_sclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cpol = 1'b0;
    logic [3:0] scale = '0;
    logic [7:0] hi_cnt = 8'd1;
    logic [7:0] lo_cnt = 8'd1;
    logic       sclk, lead_pulse, trail_pulse;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    typedef struct {
        bit    lead;
        int    stamp;
        string req;
    } ev_t;
    ev_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_sclk_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .scale(scale),
        .hi_cnt(hi_cnt), .lo_cnt(lo_cnt), .sclk(sclk),
        .lead_pulse(lead_pulse), .trail_pulse(trail_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input bit lead, input int stamp, input string req);
        ev_t e;
        e.lead = lead; e.stamp = stamp; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // monitor: pops expected edges and compares as strobes appear
    always @(negedge clk) begin
        ev_t e;
        if (rst_n && (lead_pulse || trail_pulse)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected strobe at cycle", cyc, -1);
            end else begin
                e = exp_q.pop_front();
                chk(!(lead_pulse && trail_pulse) && (lead_pulse == e.lead),
                    "R10", "strobe kind (1=lead)", int'(lead_pulse), int'(e.lead));
                chk(cyc == e.stamp, e.req, "edge cycle", cyc, e.stamp);
                if (e.lead) chk(sclk != cpol, "R3", "sclk at lead", int'(sclk), int'(!cpol));
                else        chk(sclk == cpol, "R4", "sclk at trail", int'(sclk), int'(cpol));
            end
        end
    end

    // driver: program a run, push expected edges, stop right after the last one
    task automatic run_seq(input bit pol, input int s, input int hi, input int lo,
                           input int nev, input string req);
        int period, la, lr, t, last;
        bit off;
        cpol = pol; scale = 4'(s); hi_cnt = 8'(hi); lo_cnt = 8'(lo);
        @(negedge clk);
        period = 1 << s;
        off = (hi == 0) || (lo == 0);
        la = off ? 1 : (pol ? lo : hi);
        lr = off ? 1 : (pol ? hi : lo);
        t = cyc + 1;
        enable = 1'b1;
        last = t;
        for (int k = 0; k < nev; k++) begin
            push(k % 2 == 0, t, req);
            last = t;
            t += ((k % 2 == 0) ? la : lr) * period;
        end
        wait_cyc(last);
        enable = 1'b0;
        @(negedge clk);
        chk(sclk == pol, "R9", "sclk after stop", int'(sclk), int'(pol));
        chk(exp_q.size() == 0, req, "missing edges", exp_q.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0 && !lead_pulse && !trail_pulse, "R1", "outputs in reset",
            int'({sclk, lead_pulse, trail_pulse}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b0 && !lead_pulse && !trail_pulse, "R1", "outputs after reset",
            int'({sclk, lead_pulse, trail_pulse}), 0);

        // R2: idle level follows polarity
        cpol = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1, "R2", "idle sclk with cpol=1", int'(sclk), 1);
        cpol = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0, "R2", "idle sclk with cpol=0", int'(sclk), 0);

        run_seq(1'b0, 0, 3, 5, 6, "R5");
        run_seq(1'b1, 0, 2, 4, 6, "R5");
        run_seq(1'b0, 0, 255, 1, 3, "R5");
        run_seq(1'b0, 2, 2, 1, 5, "R6");
        run_seq(1'b1, 15, 1, 0, 2, "R6");
        run_seq(1'b0, 1, 0, 7, 4, "R7");
        run_seq(1'b1, 0, 9, 0, 4, "R7");

        // R8: counts changed mid-phase apply from the next phase entered
        cpol = 1'b0; scale = 4'd0; hi_cnt = 8'd5; lo_cnt = 8'd3;
        @(negedge clk);
        c = cyc;
        enable = 1'b1;
        push(1'b1, c + 1,  "R8");
        push(1'b0, c + 6,  "R8");
        push(1'b1, c + 9,  "R8");
        push(1'b0, c + 11, "R8");
        push(1'b1, c + 17, "R8");
        wait_cyc(c + 3);  hi_cnt = 8'd2;
        wait_cyc(c + 7);  lo_cnt = 8'd6;
        wait_cyc(c + 17);
        enable = 1'b0;
        @(negedge clk);
        chk(exp_q.size() == 0, "R8", "missing edges", exp_q.size(), 0);
        repeat (3) @(negedge clk);

        // R9: stop in the middle of an active phase, then restart
        cpol = 1'b1; scale = 4'd2; hi_cnt = 8'd4; lo_cnt = 8'd4;
        @(negedge clk);
        c = cyc;
        enable = 1'b1;
        push(1'b1, c + 1, "R9");
        wait_cyc(c + 6);
        enable = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b1, "R9", "sclk right after mid-phase stop", int'(sclk), 1);
        repeat (30) @(negedge clk);
        chk(sclk == 1'b1, "R9", "sclk held idle after stop", int'(sclk), 1);
        chk(exp_q.size() == 0, "R9", "pending edges after stop", exp_q.size(), 0);
        run_seq(1'b1, 2, 4, 4, 3, "R9");

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule